// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged Cache Lookup

This block is the lookup path of a set-associative cache whose set is chosen from address bits that need no translation. The set-index field lies wholly inside the page offset. A lookup can therefore read the tag and line arrays while a small fully associative translation table converts the virtual page number into a physical page frame. The array read and the translation finish in the same cycle, and both results are captured in one pipeline register. In the next cycle, every way's stored physical tag is compared with the translated frame. The matching line is selected, and hit, miss or translation fault is reported from a registered output.

By default the block has 4 KB pages, 64-byte lines and four ways. The six index bits and six line-offset bits together fill the 12-bit page offset. A new request may be presented on every cycle. Lines are installed through a fill port, which places each line in the way named by a per-set rotating victim pointer. Translation entries are written through a separate slot-addressed port. A translation miss raises a fault flag and is otherwise left to the requester.

Top module: `vipt_cache_lookup`

## Requirements
- R1: After a synchronous active-low reset, the block gives no response, holds no valid line, and holds no valid translation. A lookup made right after reset therefore reports a fault.
- R2: The set comes only from req_vaddr[11:6]. Bits [5:0] have no effect on the result, so two virtual pages that translate to the same frame hit the same line.
- R3: A request sampled at clock edge n gives its response on the outputs after edge n+1. resp_valid is high only for cycles that carry such a response.
- R4: The translation table has 8 slots and is searched fully associatively over the valid slots. When several valid slots hold the same virtual page number, the lowest-numbered slot supplies the frame.
- R5: When no valid slot matches, the response has resp_fault=1 and resp_hit=0.
- R6: A hit occurs when a valid way of the set stores a tag equal to the translated frame (vaddr[31:12] mapped to a 20-bit frame). resp_data is then that way's line and resp_way is that way's number.
- R7: A translated lookup with no matching way gives resp_hit=0, resp_fault=0 and resp_data all zero.
- R8: Each fill writes its tag and line into the way given by the set's victim pointer and marks that way valid. The pointer starts at way 0 and then advances by one, wrapping from 3 to 0.
- R9: A lookup sampled on the same edge as a fill or a translation write sees the contents from before that write.
- R10: Writing an occupied translation slot replaces its mapping for all later lookups.
- R11: Requests on consecutive cycles each get their own response on consecutive cycles, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual byte address of the lookup |
| resp_valid | output | 1 | A response is present |
| resp_hit | output | 1 | The line was found |
| resp_fault | output | 1 | The page number had no translation |
| resp_way | output | 2 | Way that hit |
| resp_data | output | 512 | Line contents on a hit, zero otherwise |
| fill_valid | input | 1 | Install a line |
| fill_index | input | 6 | Set to install into |
| fill_ptag | input | 20 | Physical frame stored as the tag |
| fill_data | input | 512 | Line contents to install |
| tlb_wr_en | input | 1 | Write a translation slot |
| tlb_wr_slot | input | 3 | Slot number to write |
| tlb_wr_vpn | input | 20 | Virtual page number for the slot |
| tlb_wr_ppn | input | 20 | Physical frame for the slot |

## Verification
The stimulus includes two virtual pages that alias to one frame, each looked up at different line offsets. This separates true physical tagging and offset-only indexing from designs that tag with the virtual page or index with upper bits. Five fills into one set confirm the rotation order of the victim pointer and the eviction on wrap. Duplicate and rewritten translation slots confirm the slot priority and the replacement behaviour. A lookup issued on the same edge as a fill shows whether the array read is taken before the write. A burst of back-to-back requests that mixes hits, misses and faults across several sets, with fills interleaved, checks that the pipeline keeps the responses in order with no bubbles.

// File: rtl/vipt_pkg.sv
// Package: shared response classification for the lookup pipeline.
// Assumes: consumers decode the enum into separate flags at the block edge.
package vipt_pkg;

    typedef enum logic [1:0] {
        RESP_NONE  = 2'd0,
        RESP_HIT   = 2'd1,
        RESP_MISS  = 2'd2,
        RESP_FAULT = 2'd3
    } resp_kind_e;

endpackage

// File: rtl/vipt_xlat_table.sv
// Module: vipt_xlat_table
// A small fully associative page translation table with a slot-addressed
// write port and a combinational lookup. Duplicate matches resolve to the
// lowest slot number.
// Assumes: the lookup result is registered by the caller; a write becomes
// visible to lookups from the following cycle.
module vipt_xlat_table #(
    parameter int ENTRIES = 8,
    parameter int SLOT_W  = 3,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn
);

    logic [ENTRIES-1:0] slot_live;
    logic [VPN_W-1:0]   slot_vpn [ENTRIES];
    logic [PPN_W-1:0]   slot_ppn [ENTRIES];
    logic [ENTRIES-1:0] slot_match;

    // Valid bits: cleared by reset, set by any write to the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_live <= '0;
        end else if (wr_en) begin
            slot_live[wr_slot] <= 1'b1;
        end
    end

    // Mapping storage: plain registers, no reset needed behind valid bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_vpn[wr_slot] <= wr_vpn;
            slot_ppn[wr_slot] <= wr_ppn;
        end
    end

    // One comparator per slot.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign slot_match[e] = slot_live[e] && (slot_vpn[e] == lk_vpn);
    end

    // Priority select: the lowest matching slot wins.
    always_comb begin
        lk_hit = |slot_match;
        lk_ppn = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (slot_match[e]) begin
                lk_ppn = slot_ppn[e];
            end
        end
    end

endmodule

// File: rtl/vipt_way_store.sv
// Module: vipt_way_store
// Tag, line and valid storage for all ways, with a combinational read of one
// set and a fill port that writes the way named by a per-set rotating victim
// pointer.
// Assumes: the reader registers the read result; a fill on the same edge is
// not seen by that read.
module vipt_way_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int IDX_W  = 6,
    parameter int WAY_W  = 2,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             rd_index,
    output logic [WAYS-1:0]              rd_vld,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][LINE_W-1:0]  rd_line,
    input  logic                         fill_en,
    input  logic [IDX_W-1:0]             fill_index,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic [LINE_W-1:0]            fill_line
);

    logic [WAY_W-1:0] victim_ptr [SETS];
    logic [WAY_W-1:0] victim;

    assign victim = victim_ptr[fill_index];

    // Rotating victim pointer per set: starts at way 0, advances per fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                victim_ptr[s] <= '0;
            end
        end else if (fill_en) begin
            if (victim == WAY_W'(WAYS - 1)) begin
                victim_ptr[fill_index] <= '0;
            end else begin
                victim_ptr[fill_index] <= victim + 1'b1;
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]  tag_mem  [SETS];
        logic [LINE_W-1:0] line_mem [SETS];
        logic [SETS-1:0]   line_live;
        logic              way_sel;

        assign way_sel = fill_en && (victim == WAY_W'(w));

        // Valid bits of this way: cleared by reset, set by a fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_live <= '0;
            end else if (way_sel) begin
                line_live[fill_index] <= 1'b1;
            end
        end

        // Tag and line arrays of this way: written only by a fill.
        always_ff @(posedge clk) begin
            if (way_sel) begin
                tag_mem[fill_index]  <= fill_tag;
                line_mem[fill_index] <= fill_line;
            end
        end

        assign rd_vld[w]  = line_live[rd_index];
        assign rd_tag[w]  = tag_mem[rd_index];
        assign rd_line[w] = line_mem[rd_index];
    end

endmodule

// File: rtl/vipt_tag_match.sv
// Module: vipt_tag_match
// Second-stage logic: compares every way's physical tag with the translated
// frame, picks the matching way and classifies the response.
// Assumes: inputs come from the stage register; the lowest matching way wins
// if more than one matches.
module vipt_tag_match
    import vipt_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 512
) (
    input  logic                         in_valid,
    input  logic                         xlat_ok,
    input  logic [TAG_W-1:0]             frame,
    input  logic [WAYS-1:0]              way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
    input  logic [WAYS-1:0][LINE_W-1:0]  way_line,
    output resp_kind_e                   kind,
    output logic [WAY_W-1:0]             hit_way,
    output logic [LINE_W-1:0]            hit_line
);

    logic [WAYS-1:0]  way_match;
    logic [WAY_W-1:0] first_way;

    // One tag comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = way_vld[w] && (way_tag[w] == frame);
    end

    // Lowest matching way.
    always_comb begin
        first_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                first_way = WAY_W'(w);
            end
        end
    end

    // Classify the lookup and steer the line out only on a hit.
    always_comb begin
        if (!in_valid) begin
            kind = RESP_NONE;
        end else if (!xlat_ok) begin
            kind = RESP_FAULT;
        end else if (|way_match) begin
            kind = RESP_HIT;
        end else begin
            kind = RESP_MISS;
        end
        hit_way  = (kind == RESP_HIT) ? first_way : '0;
        hit_line = (kind == RESP_HIT) ? way_line[first_way] : '0;
    end

endmodule

// File: rtl/vipt_cache_lookup.sv
// Module: vipt_cache_lookup (top)
// Two-stage set-associative lookup. Stage one indexes the arrays with
// page-offset bits while the page number is translated; both are captured in
// one stage register. Stage two compares physical tags and registers the
// response.
// Assumes: index bits plus line-offset bits fit inside the page offset;
// WAYS is at least 2.
module vipt_cache_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int LINE_BYTES = 64,
    parameter int WAYS       = 4,
    parameter int XLAT_SLOTS = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic [VA_W-1:0]                        req_vaddr,
    output logic                                   resp_valid,
    output logic                                   resp_hit,
    output logic                                   resp_fault,
    output logic [$clog2(WAYS)-1:0]                resp_way,
    output logic [LINE_BYTES*8-1:0]                resp_data,
    input  logic                                   fill_valid,
    input  logic [$clog2(PAGE_BYTES/LINE_BYTES)-1:0] fill_index,
    input  logic [PA_W-$clog2(PAGE_BYTES)-1:0]     fill_ptag,
    input  logic [LINE_BYTES*8-1:0]                fill_data,
    input  logic                                   tlb_wr_en,
    input  logic [$clog2(XLAT_SLOTS)-1:0]          tlb_wr_slot,
    input  logic [VA_W-$clog2(PAGE_BYTES)-1:0]     tlb_wr_vpn,
    input  logic [PA_W-$clog2(PAGE_BYTES)-1:0]     tlb_wr_ppn
);

    localparam int PAGE_OFF_W = $clog2(PAGE_BYTES);
    localparam int LINE_OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W      = PAGE_OFF_W - LINE_OFF_W;
    localparam int SETS       = 1 << IDX_W;
    localparam int VPN_W      = VA_W - PAGE_OFF_W;
    localparam int PPN_W      = PA_W - PAGE_OFF_W;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int SLOT_W     = $clog2(XLAT_SLOTS);

    logic [IDX_W-1:0]               set_idx;
    logic [VPN_W-1:0]               page_num;
    logic                           xl_hit;
    logic [PPN_W-1:0]               xl_ppn;
    logic [WAYS-1:0]                rd_vld;
    logic [WAYS-1:0][PPN_W-1:0]     rd_tag;
    logic [WAYS-1:0][LINE_W-1:0]    rd_line;

    logic                           s1_valid;
    logic                           s1_xlat_ok;
    logic [PPN_W-1:0]               s1_frame;
    logic [WAYS-1:0]                s1_vld;
    logic [WAYS-1:0][PPN_W-1:0]     s1_tag;
    logic [WAYS-1:0][LINE_W-1:0]    s1_line;

    resp_kind_e                     s2_kind;
    logic [WAY_W-1:0]               s2_way;
    logic [LINE_W-1:0]              s2_line;

    assign set_idx  = req_vaddr[PAGE_OFF_W-1:LINE_OFF_W];
    assign page_num = req_vaddr[VA_W-1:PAGE_OFF_W];

    vipt_xlat_table #(
        .ENTRIES (XLAT_SLOTS),
        .SLOT_W  (SLOT_W),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_xlat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tlb_wr_en),
        .wr_slot (tlb_wr_slot),
        .wr_vpn  (tlb_wr_vpn),
        .wr_ppn  (tlb_wr_ppn),
        .lk_vpn  (page_num),
        .lk_hit  (xl_hit),
        .lk_ppn  (xl_ppn)
    );

    vipt_way_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .IDX_W  (IDX_W),
        .WAY_W  (WAY_W),
        .TAG_W  (PPN_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_index   (set_idx),
        .rd_vld     (rd_vld),
        .rd_tag     (rd_tag),
        .rd_line    (rd_line),
        .fill_en    (fill_valid),
        .fill_index (fill_index),
        .fill_tag   (fill_ptag),
        .fill_line  (fill_data)
    );

    // Stage boundary, control half: request strobe under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= req_valid;
        end
    end

    // Stage boundary, data half: translated frame and the set read.
    always_ff @(posedge clk) begin
        s1_xlat_ok <= xl_hit;
        s1_frame   <= xl_ppn;
        s1_vld     <= rd_vld;
        s1_tag     <= rd_tag;
        s1_line    <= rd_line;
    end

    vipt_tag_match #(
        .WAYS   (WAYS),
        .WAY_W  (WAY_W),
        .TAG_W  (PPN_W),
        .LINE_W (LINE_W)
    ) u_match (
        .in_valid (s1_valid),
        .xlat_ok  (s1_xlat_ok),
        .frame    (s1_frame),
        .way_vld  (s1_vld),
        .way_tag  (s1_tag),
        .way_line (s1_line),
        .kind     (s2_kind),
        .hit_way  (s2_way),
        .hit_line (s2_line)
    );

    // Response register: decode the classification into output flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b0;
            resp_way   <= '0;
            resp_data  <= '0;
        end else begin
            resp_valid <= (s2_kind != RESP_NONE);
            resp_hit   <= (s2_kind == RESP_HIT);
            resp_fault <= (s2_kind == RESP_FAULT);
            resp_way   <= s2_way;
            resp_data  <= s2_line;
        end
    end

endmodule

// File: rtl/vipt_cache_lookup_chk.sv
// Module: vipt_cache_lookup_chk
// Protocol checks on the lookup block's ports, bound to every instance.
// Assumes: a cycle counter since reset bounds all history looks.
module vipt_cache_lookup_chk #(
    parameter int LINE_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_fault,
    input logic [LINE_W-1:0] resp_data
);

    logic [1:0] since_rst;

    // Count edges out of reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_RESP_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (resp_valid == $past(req_valid, 2))); // R3

    AST_FRESH_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd2) |-> !resp_valid); // R1

    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!resp_hit && !resp_fault)); // R1

    AST_FAULT_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> !resp_hit); // R5

    AST_MISS_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_data == '0)); // R7

endmodule

bind vipt_cache_lookup vipt_cache_lookup_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_fault (resp_fault),
    .resp_data  (resp_data)
);

// File: tb/vipt_cache_lookup_tb.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module vipt_cache_lookup_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 512;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [31:0]       req_vaddr;
    logic              resp_valid;
    logic              resp_hit;
    logic              resp_fault;
    logic [1:0]        resp_way;
    logic [LINE_W-1:0] resp_data;
    logic              fill_valid;
    logic [5:0]        fill_index;
    logic [19:0]       fill_ptag;
    logic [LINE_W-1:0] fill_data;
    logic              tlb_wr_en;
    logic [2:0]        tlb_wr_slot;
    logic [19:0]       tlb_wr_vpn;
    logic [19:0]       tlb_wr_ppn;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string phase  = "R1 reset";

    always #(CLK_PERIOD / 2) clk = ~clk;

    vipt_cache_lookup u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .resp_valid  (resp_valid),
        .resp_hit    (resp_hit),
        .resp_fault  (resp_fault),
        .resp_way    (resp_way),
        .resp_data   (resp_data),
        .fill_valid  (fill_valid),
        .fill_index  (fill_index),
        .fill_ptag   (fill_ptag),
        .fill_data   (fill_data),
        .tlb_wr_en   (tlb_wr_en),
        .tlb_wr_slot (tlb_wr_slot),
        .tlb_wr_vpn  (tlb_wr_vpn),
        .tlb_wr_ppn  (tlb_wr_ppn)
    );

    // ---------------- reference model ----------------
    typedef struct {
        bit                v;
        bit                hit;
        bit                fault;
        int                way;
        logic [LINE_W-1:0] data;
    } exp_t;

    bit                m_tv   [8];
    logic [19:0]       m_tvpn [8];
    logic [19:0]       m_tppn [8];
    bit                m_cv   [64][4];
    logic [19:0]       m_ctag [64][4];
    logic [LINE_W-1:0] m_cdat [64][4];
    int                m_rr   [64];
    exp_t              exp_s1;
    exp_t              exp_out;

    function automatic exp_t no_resp();
        exp_t r;
        r.v = 0; r.hit = 0; r.fault = 0; r.way = 0; r.data = '0;
        return r;
    endfunction

    function automatic exp_t model_lookup(logic [31:0] va);
        exp_t r;
        int   slot;
        int   idx;
        r = no_resp();
        r.v = 1;
        slot = -1;
        idx = int'(va[11:6]);
        for (int e = 0; e < 8; e++)
            if (slot < 0 && m_tv[e] && m_tvpn[e] == va[31:12]) slot = e;
        if (slot < 0) begin
            r.fault = 1;
            return r;
        end
        for (int w = 0; w < 4; w++)
            if (!r.hit && m_cv[idx][w] && m_ctag[idx][w] == m_tppn[slot]) begin
                r.hit = 1; r.way = w; r.data = m_cdat[idx][w];
            end
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] mkline(int seed);
        logic [LINE_W-1:0] l;
        for (int k = 0; k < LINE_W / 32; k++)
            l[k*32 +: 32] = 32'(seed) * 32'h0100_0193 + 32'(k) * 32'h9E37_79B1;
        return l;
    endfunction

    // Model update at each rising edge: respond from state before writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < 8; e++) m_tv[e] = 0;
            for (int s = 0; s < 64; s++) begin
                m_rr[s] = 0;
                for (int w = 0; w < 4; w++) m_cv[s][w] = 0;
            end
            exp_s1  = no_resp();
            exp_out = no_resp();
        end else begin
            exp_out = exp_s1;
            exp_s1  = req_valid ? model_lookup(req_vaddr) : no_resp();
            if (tlb_wr_en) begin
                m_tv[tlb_wr_slot]   = 1;
                m_tvpn[tlb_wr_slot] = tlb_wr_vpn;
                m_tppn[tlb_wr_slot] = tlb_wr_ppn;
            end
            if (fill_valid) begin
                int w;
                w = m_rr[fill_index];
                m_cv[fill_index][w]   = 1;
                m_ctag[fill_index][w] = fill_ptag;
                m_cdat[fill_index][w] = fill_data;
                m_rr[fill_index]      = (w + 1) % 4;
            end
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (resp_valid !== exp_out.v) begin
                errors++;
                $display("FAIL %s: resp_valid=%0b expected %0b", phase, resp_valid, exp_out.v);
            end else if (exp_out.v) begin
                if (resp_hit !== exp_out.hit || resp_fault !== exp_out.fault) begin
                    errors++;
                    $display("FAIL %s: hit/fault=%0b/%0b expected %0b/%0b",
                             phase, resp_hit, resp_fault, exp_out.hit, exp_out.fault);
                end else if (int'(resp_way) != exp_out.way && exp_out.hit) begin
                    errors++;
                    $display("FAIL %s: resp_way=%0d expected %0d", phase, resp_way, exp_out.way);
                end else if (resp_data !== exp_out.data) begin
                    errors++;
                    $display("FAIL %s: resp_data=%h expected %h", phase, resp_data, exp_out.data);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        req_valid  = 1'b0;
        fill_valid = 1'b0;
        tlb_wr_en  = 1'b0;
    endtask

    task automatic set_req(logic [19:0] vpn, logic [5:0] idx, logic [5:0] off);
        req_valid = 1'b1;
        req_vaddr = {vpn, idx, off};
    endtask

    task automatic set_fill(logic [5:0] idx, logic [19:0] tag, int seed);
        fill_valid = 1'b1;
        fill_index = idx;
        fill_ptag  = tag;
        fill_data  = mkline(seed);
    endtask

    task automatic set_xlat(logic [2:0] slot, logic [19:0] vpn, logic [19:0] ppn);
        tlb_wr_en   = 1'b1;
        tlb_wr_slot = slot;
        tlb_wr_vpn  = vpn;
        tlb_wr_ppn  = ppn;
    endtask

    task automatic settle();
        tick(); tick(); tick();
    endtask

    task automatic report();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: cycles=%0d expected below %0d", WATCHDOG, WATCHDOG);
            report();
        end
    end

    // ---------------- directed and burst stimulus ----------------
    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_vaddr = '0;
        fill_valid = 1'b0; fill_index = '0; fill_ptag = '0; fill_data = '0;
        tlb_wr_en = 1'b0; tlb_wr_slot = '0; tlb_wr_vpn = '0; tlb_wr_ppn = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        phase = "R1 empty after reset faults";
        set_req(20'h00010, 6'd5, 6'd0); tick();
        settle();

        phase = "R5 unmapped page faults";
        set_xlat(3'd0, 20'h00010, 20'h00ABC); tick();
        set_xlat(3'd1, 20'h00020, 20'h00ABC); tick();
        set_req(20'h00040, 6'd5, 6'd0); tick();
        settle();

        phase = "R7 mapped page misses";
        set_req(20'h00010, 6'd5, 6'd8); tick();
        settle();

        phase = "R8 first fill to way 0";
        set_fill(6'd5, 20'h00ABC, 1); tick();
        phase = "R6 hit returns line";
        set_req(20'h00010, 6'd5, 6'd0); tick();
        settle();

        phase = "R2 alias page and offset ignored";
        set_req(20'h00020, 6'd5, 6'd63); tick();
        set_req(20'h00010, 6'd5, 6'd17); tick();
        set_req(20'h00020, 6'd6, 6'd0); tick();
        settle();

        phase = "R8 rotation and wrap";
        set_xlat(3'd2, 20'h00030, 20'h00111); tick();
        set_fill(6'd5, 20'h00111, 2); tick();
        set_fill(6'd5, 20'h00222, 3); tick();
        set_fill(6'd5, 20'h00333, 4); tick();
        set_req(20'h00030, 6'd5, 6'd0); tick();
        set_req(20'h00010, 6'd5, 6'd0); tick();
        set_fill(6'd5, 20'h00444, 5); tick();
        set_req(20'h00010, 6'd5, 6'd0); tick();
        set_req(20'h00030, 6'd5, 6'd4); tick();
        settle();

        phase = "R9 lookup alongside fill";
        set_req(20'h00010, 6'd9, 6'd0);
        set_fill(6'd9, 20'h00ABC, 6); tick();
        set_req(20'h00010, 6'd9, 6'd0); tick();
        settle();

        phase = "R9 lookup alongside translation write";
        set_req(20'h00050, 6'd9, 6'd0);
        set_xlat(3'd4, 20'h00050, 20'h00ABC); tick();
        set_req(20'h00050, 6'd9, 6'd0); tick();
        settle();

        phase = "R4 duplicate slots lowest wins";
        set_xlat(3'd3, 20'h00030, 20'h00555); tick();
        set_fill(6'd12, 20'h00111, 7); tick();
        set_req(20'h00030, 6'd12, 6'd0); tick();
        settle();

        phase = "R10 slot rewrite remaps";
        set_xlat(3'd2, 20'h00099, 20'h00111); tick();
        set_req(20'h00030, 6'd12, 6'd0); tick();
        set_fill(6'd12, 20'h00555, 8); tick();
        set_req(20'h00030, 6'd12, 6'd0); tick();
        set_req(20'h00099, 6'd12, 6'd0); tick();
        settle();

        phase = "R11 back-to-back burst";
        for (int s = 0; s < 8; s++) begin
            set_fill(6'(s + 16), 20'h00ABC, 20 + s); tick();
        end
        for (int i = 0; i < 48; i++) begin
            logic [19:0] vp;
            case (i % 4)
                0: vp = 20'h00010;
                1: vp = 20'h00020;
                2: vp = 20'h00030;
                default: vp = 20'h00077;
            endcase
            set_req(vp, 6'(16 + (i * 3) % 10), 6'(i));
            if (i % 5 == 2) set_fill(6'(16 + (i % 10)), 20'h00555, 40 + i);
            tick();
        end
        settle();

        phase = "R3 idle gaps give no response";
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) set_req(20'h00010, 6'd16, 6'd0);
            tick();
        end
        settle();

        report();
    end

endmodule